// File: doc/BRIEF.md
# PRBS Link Bit-Error Tester

This block checks a one-bit-per-clock serial link end to end. A transmitter and a receiver sit in the same block, and their link-side ports are exposed so that the link in between, or a test harness, can sit between them. While the `start` input is low, the transmitter is silent. Once `start` is high, it sends a fixed 32-bit synchronization word and then an endless pseudo-random stream from a 31-bit LFSR. The `form` input selects whether that LFSR is built in Fibonacci or in Galois form, and the two forms give different streams.

The receiver is armed by the same `start` input. It shifts incoming valid bits through a 32-bit window until the window holds the synchronization word. It then declares lock and starts its own copy of the generator. From the bit that follows the synchronization word, every valid received bit is compared with the local expected bit. Two saturating counters record the bits checked and the mismatches. A small read port returns either counter or a status word.

Top module: `prbs_bert`

## Requirements
- R1: While `start` is low at a clock edge, `link_tx_valid` and `link_tx_bit` are 0 for the following cycle.
- R2: In the first 32 cycles after the edge that samples `start` high, `link_tx_valid` is 1 and `link_tx_bit` carries 0xAAAA5555, most significant bit first.
- R3: With `form`=0 (Fibonacci), the bits after the sync word come from a 31-bit state S loaded with SEED. Each output bit is S[30], and the state then steps to {S[29:0], S[30]^S[27]}.
- R4: With `form`=1 (Galois), the output bit is S[0], and the state then steps to (S>>1) XOR (S[0] ? 0x48000000 : 0), with S loaded with SEED.
- R5: The receiver shifts each valid bit into a 32-bit window. `locked` rises in the cycle after the edge that shifts in the last bit of a complete 0xAAAA5555, and never earlier, even when a partial prefix of that word has arrived before.
- R6: Once locked, each bit with `link_rx_valid`=1 that differs from the local generator bit adds one to the error count. Bits with `link_rx_valid`=0 change nothing and do not step the generator.
- R7: Once locked, each bit with `link_rx_valid`=1 adds one to the bit count, so the bit count is never below the error count.
- R8: Both counters saturate at all ones instead of wrapping.
- R9: A high `cnt_clear` at an edge zeroes both counters and wins over any increment at that edge.
- R10: A low `start` drops lock, empties the receive window and reloads both generators with SEED. The counters keep their values.
- R11: `rd_data` follows `rd_addr` combinationally: 0 returns the error count, 1 the bit count, 2 returns {form, locked} in bits 1:0, and 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms the transmitter and receiver |
| form | input | 1 | LFSR form: 0 Fibonacci, 1 Galois |
| cnt_clear | input | 1 | Synchronous clear of both counters |
| link_tx_bit | output | 1 | Serial bit sent to the link |
| link_tx_valid | output | 1 | Transmit bit is meaningful |
| link_rx_bit | input | 1 | Serial bit received from the link |
| link_rx_valid | input | 1 | Receive bit is meaningful |
| locked | output | 1 | Sync word found; checking active |
| rd_addr | input | 2 | Register select |
| rd_data | output | CNT_W | Selected register value |

## Verification
The bench builds the block with CNT_W=8 and keeps the default 31-bit polynomial and seed. With 8-bit counters, runs of a few hundred bits drive both counters into saturation, which a 32-bit counter would never reach in a short run. The stream lengths and error spacings in the table walk both LFSR forms across the whole range from no errors to saturation. Directed runs feed the receiver a false partial prefix of the sync word, valid gaps and a clear that collides with an increment.

// File: rtl/prbs_pkg.sv
// Package: shared constants and types for the PRBS bit-error tester.
// Assumes a link carrying one bit per clock and a 32-bit sync word.
package prbs_pkg;

    localparam int          SYNC_W    = 32;
    localparam logic [31:0] SYNC_WORD = 32'hAAAA_5555;

    typedef enum logic {
        FORM_FIB = 1'b0,
        FORM_GAL = 1'b1
    } lfsr_form_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SYNC = 2'd1,
        TX_PRBS = 2'd2
    } tx_state_e;

    localparam logic [1:0] REG_ERRS   = 2'd0;
    localparam logic [1:0] REG_BITS   = 2'd1;
    localparam logic [1:0] REG_STATUS = 2'd2;

endpackage

// File: rtl/prbs_lfsr.sv
// Module: prbs_lfsr
// A two-tap LFSR that runs in Fibonacci or Galois form, chosen at run time.
// Assumes LEN > TAP >= 1 and a nonzero SEED. When reload and advance are
// both high, reload wins. The output bit shows the current state's bit.
module prbs_lfsr
    import prbs_pkg::*;
#(
    parameter int             LEN  = 31,
    parameter int             TAP  = 28,
    parameter logic [LEN-1:0] SEED = 31'h1ACE_2B5F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic form,
    input  logic reload,
    input  logic advance,
    output logic bit_out
);

    localparam logic [LEN-1:0] GAL_MASK = (LEN'(1) << (LEN - 1)) | (LEN'(1) << (TAP - 1));

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] fib_next;
    logic [LEN-1:0] gal_next;

    // Next state for each form.
    always_comb begin
        fib_next = {state_q[LEN-2:0], state_q[LEN-1] ^ state_q[TAP-1]};
        gal_next = (state_q >> 1) ^ (state_q[0] ? GAL_MASK : '0);
    end

    // Output bit for the selected form.
    assign bit_out = (form == FORM_GAL) ? state_q[0] : state_q[LEN-1];

    // State register: seed on reset or reload, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= (form == FORM_GAL) ? gal_next : fib_next;
        end
    end

endmodule

// File: rtl/prbs_sat_counter.sv
// Module: prbs_sat_counter
// An up-counter that stops at all ones. Clear has priority over increment.
module prbs_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic at_max;

    assign at_max = &count;

    // Count register: clear, else step unless saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc && !at_max) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/prbs_tx.sv
// Module: prbs_tx
// Transmit side. While start is low it idles. Once start is seen high it
// sends the sync word MSB first, then the generator stream, one bit per
// clock. The output is decoded from registered state.
module prbs_tx
    import prbs_pkg::*;
#(
    parameter int             LEN  = 31,
    parameter int             TAP  = 28,
    parameter logic [LEN-1:0] SEED = 31'h1ACE_2B5F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic form,
    output logic tx_bit,
    output logic tx_valid
);

    localparam int CW = $clog2(SYNC_W);

    tx_state_e     state_q;
    logic [CW-1:0] idx_q;
    logic          gen_bit;

    prbs_lfsr #(.LEN(LEN), .TAP(TAP), .SEED(SEED)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .form   (form),
        .reload (!start),
        .advance(state_q == TX_PRBS),
        .bit_out(gen_bit)
    );

    // Sequencer: idle, then sync word, then pseudo-random stream.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    state_q <= TX_SYNC;
                    idx_q   <= '0;
                end
                TX_SYNC: begin
                    if (idx_q == CW'(SYNC_W - 1)) begin
                        state_q <= TX_PRBS;
                    end
                    idx_q <= idx_q + CW'(1);
                end
                default: state_q <= TX_PRBS;
            endcase
        end
    end

    // Output decode for the current state.
    always_comb begin
        unique case (state_q)
            TX_SYNC: tx_bit = SYNC_WORD[CW'(SYNC_W - 1) - idx_q];
            TX_PRBS: tx_bit = gen_bit;
            default: tx_bit = 1'b0;
        endcase
        tx_valid = (state_q != TX_IDLE);
    end

endmodule

// File: rtl/prbs_rx.sv
// Module: prbs_rx
// Receive side. It hunts for the sync word one valid bit at a time. After
// the whole word has arrived it locks, starts its generator and compares
// each following valid bit. It emits one-cycle check and error pulses.
module prbs_rx
    import prbs_pkg::*;
#(
    parameter int             LEN  = 31,
    parameter int             TAP  = 28,
    parameter logic [LEN-1:0] SEED = 31'h1ACE_2B5F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic form,
    input  logic rx_bit,
    input  logic rx_valid,
    output logic locked,
    output logic chk_pulse,
    output logic err_pulse
);

    logic [SYNC_W-1:0] win_q;
    logic [SYNC_W-1:0] win_next;
    logic              exp_bit;

    assign win_next  = {win_q[SYNC_W-2:0], rx_bit};
    assign chk_pulse = start && locked && rx_valid;
    assign err_pulse = chk_pulse && (rx_bit != exp_bit);

    prbs_lfsr #(.LEN(LEN), .TAP(TAP), .SEED(SEED)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .form   (form),
        .reload (!start),
        .advance(chk_pulse),
        .bit_out(exp_bit)
    );

    // Sync hunt: shift valid bits in until the window equals the sync word.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) begin
            win_q  <= '0;
            locked <= 1'b0;
        end else if (!locked && rx_valid) begin
            win_q <= win_next;
            if (win_next == SYNC_WORD) begin
                locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/prbs_bert.sv
// Module: prbs_bert (top)
// Holds the transmitter, the receiver, the two saturating counters and the
// read port. The link between the transmit and receive ports is external.
// Assumes CNT_W >= 2 so the status word fits in rd_data.
module prbs_bert
    import prbs_pkg::*;
#(
    parameter int             CNT_W = 32,
    parameter int             LEN   = 31,
    parameter int             TAP   = 28,
    parameter logic [LEN-1:0] SEED  = 31'h1ACE_2B5F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             form,
    input  logic             cnt_clear,
    output logic             link_tx_bit,
    output logic             link_tx_valid,
    input  logic             link_rx_bit,
    input  logic             link_rx_valid,
    output logic             locked,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data
);

    logic             chk_pulse;
    logic             err_pulse;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] bit_cnt;

    prbs_tx #(.LEN(LEN), .TAP(TAP), .SEED(SEED)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .form    (form),
        .tx_bit  (link_tx_bit),
        .tx_valid(link_tx_valid)
    );

    prbs_rx #(.LEN(LEN), .TAP(TAP), .SEED(SEED)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .form     (form),
        .rx_bit   (link_rx_bit),
        .rx_valid (link_rx_valid),
        .locked   (locked),
        .chk_pulse(chk_pulse),
        .err_pulse(err_pulse)
    );

    prbs_sat_counter #(.W(CNT_W)) u_err_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .inc  (err_pulse),
        .count(err_cnt)
    );

    prbs_sat_counter #(.W(CNT_W)) u_bit_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .inc  (chk_pulse),
        .count(bit_cnt)
    );

    // Read port: select a counter or the status word.
    always_comb begin
        unique case (rd_addr)
            REG_ERRS:   rd_data = err_cnt;
            REG_BITS:   rd_data = bit_cnt;
            REG_STATUS: rd_data = {{(CNT_W - 2){1'b0}}, form, locked};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/prbs_bert_checker.sv
// Module: prbs_bert_checker
// Protocol properties of prbs_bert, attached to every instance by bind.
module prbs_bert_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cnt_clear,
    input logic             link_tx_bit,
    input logic             link_tx_valid,
    input logic             link_rx_valid,
    input logic             locked,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] bit_cnt
);

    // R1: a low start silences the transmitter in the next cycle.
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!link_tx_valid && !link_tx_bit));

    // R2: the first transmitted bit is the sync word's MSB, which is 1.
    p_sync_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_tx_valid) |-> link_tx_bit);

    // R5: lock can only rise after an edge that took in a valid bit.
    p_lock_on_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(link_rx_valid && start));

    // R6: the error count grows by at most one per cycle.
    p_err_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + CNT_W'(1)));

    // R7: the bit count never falls below the error count.
    p_bits_ge_errs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt >= err_cnt);

    // R8: a saturated error count stays saturated without a clear.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&err_cnt) && !cnt_clear) |=> (&err_cnt));

    // R9: a clear empties both counters.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (err_cnt == '0 && bit_cnt == '0));

    // R10: a low start drops lock.
    p_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !locked);

endmodule

bind prbs_bert prbs_bert_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cnt_clear    (cnt_clear),
    .link_tx_bit  (link_tx_bit),
    .link_tx_valid(link_tx_valid),
    .link_rx_valid(link_rx_valid),
    .locked       (locked),
    .err_cnt      (err_cnt),
    .bit_cnt      (bit_cnt)
);

// File: tb/prbs_bert_bench.sv
// Bench for prbs_bert: a table walk over loopback runs, then directed tests.
module prbs_bert_bench;

    localparam int          CNT_W = 8;
    localparam logic [30:0] SEED  = 31'h1ACE_2B5F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             form = 1'b0;
    logic             cnt_clear = 1'b0;
    logic             link_tx_bit;
    logic             link_tx_valid;
    logic             link_rx_bit;
    logic             link_rx_valid;
    logic             locked;
    logic [1:0]       rd_addr = 2'd0;
    logic [CNT_W-1:0] rd_data;

    logic manual = 1'b0;
    logic man_bit = 1'b0;
    logic man_valid = 1'b0;
    logic flip = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    assign link_rx_bit   = manual ? man_bit : (link_tx_bit ^ flip);
    assign link_rx_valid = manual ? man_valid : link_tx_valid;

    prbs_bert #(.CNT_W(CNT_W), .SEED(SEED)) u_prbs_bert (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .form         (form),
        .cnt_clear    (cnt_clear),
        .link_tx_bit  (link_tx_bit),
        .link_tx_valid(link_tx_valid),
        .link_rx_bit  (link_rx_bit),
        .link_rx_valid(link_rx_valid),
        .locked       (locked),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // Columns: form, bits sent, error spacing (0 = none), errors, bit count.
    localparam int NV = 6;
    localparam int TV [NV][5] = '{
        '{0, 100, 10, 10, 100},
        '{1, 100,  7, 14, 100},
        '{0,  50, 50,  1,  50},
        '{1,  64,  0,  0,  64},
        '{0, 300,  1, 255, 255},
        '{1, 300,  2, 150, 255}
    };

    task automatic check(input string req, input int actual, input int expected);
        checks = checks + 1;
        if (actual != expected) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // Model step and output bit, written from the R3 and R4 formulas.
    function automatic logic [30:0] model_step(input logic f, input logic [30:0] s);
        if (f) return (s >> 1) ^ (s[0] ? 31'h4800_0000 : 31'h0);
        return {s[29:0], s[30] ^ s[27]};
    endfunction

    function automatic logic model_bit(input logic f, input logic [30:0] s);
        return f ? s[0] : s[30];
    endfunction

    initial begin
        int v;
        int mism;
        logic [30:0] ms;
        logic [51:0] pre;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R11).
        check("R1 reset tx_valid", int'(link_tx_valid), 0);
        read_reg(2'd0, v); check("R11 reset errs", v, 0);
        read_reg(2'd1, v); check("R11 reset bits", v, 0);
        read_reg(2'd2, v); check("R11 reset status", v, 0);

        // Transmit stream for both forms (R2, R3, R4).
        for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            start = 1'b0;
            form = f[0];
            @(negedge clk);
            start = 1'b1;
            mism = 0;
            for (int j = 0; j < 32; j++) begin
                @(negedge clk);
                if (link_tx_bit != 1'(32'hAAAA5555 >> (31 - j)) || !link_tx_valid) mism++;
            end
            check("R2 sync word bits", mism, 0);
            check("R5 not locked before last bit", int'(locked), 0);
            ms = SEED;
            mism = 0;
            for (int j = 0; j < 64; j++) begin
                @(negedge clk);
                if (link_tx_bit != model_bit(f[0], ms)) mism++;
                ms = model_step(f[0], ms);
            end
            if (f == 0) check("R3 fibonacci stream", mism, 0);
            else check("R4 galois stream", mism, 0);
        end

        // Table walk over loopback runs (R6, R7, R8, R10).
        for (int t = 0; t < NV; t++) begin
            @(negedge clk);
            start = 1'b0;
            flip = 1'b0;
            cnt_clear = 1'b1;
            @(negedge clk);
            cnt_clear = 1'b0;
            form = TV[t][0] != 0;
            start = 1'b1;
            repeat (33) @(negedge clk);
            check("R5 locked after sync", int'(locked), 1);
            for (int i = 0; i < TV[t][1]; i++) begin
                flip = (TV[t][2] != 0) && ((i % TV[t][2]) == TV[t][2] - 1);
                @(negedge clk);
            end
            start = 1'b0;
            flip = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check("R10 unlocked on stop", int'(locked), 0);
            check("R1 idle on stop", int'(link_tx_valid), 0);
            read_reg(2'd0, v); check("R6 R8 error count", v, TV[t][3]);
            read_reg(2'd1, v); check("R7 R8 bit count", v, TV[t][4]);
        end

        // Hunt with a false partial prefix and valid gaps (R5, R6, R7, R11).
        @(negedge clk);
        cnt_clear = 1'b1;
        manual = 1'b1;
        form = 1'b0;
        @(negedge clk);
        cnt_clear = 1'b0;
        start = 1'b1;
        pre = {20'hAAAA5, 32'hAAAA5555};
        for (int j = 51; j >= 0; j--) begin
            man_bit = pre[j];
            man_valid = 1'b1;
            if (j == 0) check("R5 no early lock", int'(locked), 0);
            @(negedge clk);
        end
        check("R5 lock after full sync", int'(locked), 1);
        read_reg(2'd2, v); check("R11 status locked", v, 1);
        ms = SEED;
        for (int i = 0; i < 24; i++) begin
            if (i % 3 == 2) begin
                man_valid = 1'b0;
                man_bit = ~model_bit(1'b0, ms);
            end else begin
                man_valid = 1'b1;
                man_bit = model_bit(1'b0, ms);
                ms = model_step(1'b0, ms);
            end
            @(negedge clk);
        end
        man_valid = 1'b0;
        @(negedge clk);
        read_reg(2'd0, v); check("R6 gaps ignored errs", v, 0);
        read_reg(2'd1, v); check("R7 valid bits only", v, 16);
        man_valid = 1'b1;
        man_bit = ~model_bit(1'b0, ms);
        ms = model_step(1'b0, ms);
        @(negedge clk);
        man_valid = 1'b0;
        read_reg(2'd0, v); check("R6 single error", v, 1);
        read_reg(2'd1, v); check("R7 bit after error", v, 17);

        // Clear colliding with an increment (R9).
        man_valid = 1'b1;
        man_bit = ~model_bit(1'b0, ms);
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        man_valid = 1'b0;
        read_reg(2'd0, v); check("R9 clear errs", v, 0);
        read_reg(2'd1, v); check("R9 clear bits", v, 0);
        read_reg(2'd3, v); check("R11 spare address", v, 0);
        form = 1'b1;
        read_reg(2'd2, v); check("R11 status form", v, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule